// File: doc/BRIEF.md
# Audio DMA Address Generator

This block is a single audio DMA channel that steps through one contiguous buffer in host memory, one dword per data beat. Software loads a start address and an end address (start plus buffer size). The running address pointer advances by four bytes for each accepted beat. When the next address would equal the end address, the pointer returns to the start address and the channel keeps running. Software can read the pointer at any time to find the transfer position.

Burst requests depend on the fill level of an external FIFO. The level is given as a dword count: dwords holding data when the channel writes to memory, free dwords when it reads from memory. A request goes out once the count reaches a threshold picked by a 2-bit code. The burst then runs for a length picked by a 3-bit code. A 4-bit boundary code raises a period interrupt each time the pointer lands on a power-of-two address boundary. Software clears a pending interrupt by writing a one back to its status bit.

Host registers (word index on `host_addr`): 0 control, 1 start address, 2 end address, 3 page, 4 pointer (read only), 5 burst configuration, 6 interrupt status. Unused indices and unused bits read as zero.

Top module: `audio_dma_chan`

## Requirements
- R1: While reset is held low, all of the following are zero: the pointer, the enable bit, the pending interrupt, `mem_req` and every register. `mem_len` then reads 1.
- R2: The control register (index 0) uses bits [31:16] as a write mask for bits [15:0]. The enable bit 0 changes only when bit 16 of the write data is one. Writing 0x0001_0000 clears it, 0x0001_0001 sets it, and 0x0000_0001 leaves it unchanged.
- R3: A write to the start register (index 1) also loads the pointer with the written value. Each accepted beat adds 4 to the pointer. `mem_addr` always equals the pointer.
- R4: When an accepted beat would move the pointer to the value held in the end register (index 2), the pointer takes the start register value instead, with no pause in transfers.
- R5: The page register (index 3) holds a boundary code L in bits [7:4]. For L from 1 to 15, an accepted beat whose new pointer value has its low 5+L bits all zero sets the pending interrupt, and `irq` is high from the next cycle. Examples: L=1 gives 64 bytes, L=15 gives 1 MB. L=0 raises no interrupt.
- R6: Status (index 6) bit 0 shows the pending interrupt, and a zero read means nothing is pending. Writing a one to bit 0 clears it, and writing a zero leaves it set. If a boundary hit and a clearing write fall in the same cycle, the interrupt stays set.
- R7: The burst threshold code in configuration bits [9:8] selects 1, 4, 8 or 16 dwords (codes 0 to 3). `mem_req` rises on the clock edge after enable is set and `fifo_count` is at or above the threshold. It is never high while enable is clear.
- R8: The burst length code n in configuration bits [2:0] gives `mem_len` = 2^n dwords. After `mem_gnt`, exactly `mem_len` beats are accepted. A `mem_beat` given outside a granted burst leaves the pointer unchanged.
- R9: Clearing enable ends the burst in progress: later beats are ignored and the pointer holds its value. After enable is set again, transfers resume from the held pointer.
- R10: Page register bit 11 (address translation) always reads 0 whatever is written, so only linear addressing is used. The boundary code reads back in bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on host_addr) |
| irq | output | 1 | Pending period interrupt |
| fifo_count | input | 8 | FIFO dwords available for the transfer direction |
| mem_req | output | 1 | Burst request |
| mem_gnt | input | 1 | Burst grant |
| mem_len | output | 8 | Burst length in dwords |
| mem_beat | input | 1 | One dword beat completes this cycle |
| mem_addr | output | 32 | Byte address of the current beat |

## Verification
Two functions can act in the same cycle: a beat that lands on a boundary sets the interrupt, and a host write of one to the status bit clears it. The bench makes them meet by driving the last beat of a burst that ends on a 64-byte boundary in the same cycle as the clearing write. It then expects `irq` still high and status still reading 1, and a later clearing write on its own must bring both to zero. Wrap-around is checked the same way: the beat that returns the pointer to the start address also lands on a boundary.

// File: rtl/dma_pkg.sv
// Shared types and decode helpers for the audio DMA channel.
// Assumes a 32-bit host data path and a register index of 3 bits.
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } burst_st_t;

    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_START  = 3'd1;
    localparam logic [2:0] IDX_END    = 3'd2;
    localparam logic [2:0] IDX_PAGE   = 3'd3;
    localparam logic [2:0] IDX_PTR    = 3'd4;
    localparam logic [2:0] IDX_CFG    = 3'd5;
    localparam logic [2:0] IDX_STATUS = 3'd6;

    // Burst length code n -> 2^n dwords
    function automatic logic [7:0] len_of(input logic [2:0] code);
        return 8'd1 << code;
    endfunction

    // Threshold code -> 1, 4, 8, 16 dwords
    function automatic logic [4:0] thr_of(input logic [1:0] code);
        logic [4:0] v;
        case (code)
            2'd0:    v = 5'd1;
            2'd1:    v = 5'd4;
            2'd2:    v = 5'd8;
            default: v = 5'd16;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/dma_regs.sv
// Host register file of the DMA channel.
// Holds enable, start/end addresses, boundary code and burst config;
// decodes the masked control write and the write-one-to-clear status.
// Assumes a single-cycle write strobe and a combinational read.
module dma_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              irq_pend,
    output logic              en,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr,
    output logic [3:0]        limit,
    output logic [2:0]        burst_code,
    output logic [1:0]        thr_code,
    output logic              load_ptr,
    output logic [ADDR_W-1:0] load_val,
    output logic              irq_clr
);
    import dma_pkg::*;

    // Write decode strobes
    always_comb begin
        load_ptr = host_wr && (host_addr == IDX_START);
        load_val = host_wdata[ADDR_W-1:0];
        irq_clr  = host_wr && (host_addr == IDX_STATUS) && host_wdata[0];
    end

    // Register updates on host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            start_addr <= '0;
            end_addr   <= '0;
            limit      <= '0;
            burst_code <= '0;
            thr_code   <= '0;
        end else if (host_wr) begin
            case (host_addr)
                IDX_CTRL:  if (host_wdata[16]) en <= host_wdata[0];
                IDX_START: start_addr <= host_wdata[ADDR_W-1:0];
                IDX_END:   end_addr   <= host_wdata[ADDR_W-1:0];
                IDX_PAGE:  limit      <= host_wdata[7:4];
                IDX_CFG: begin
                    burst_code <= host_wdata[2:0];
                    thr_code   <= host_wdata[9:8];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            IDX_CTRL:   host_rdata = {31'b0, en};
            IDX_START:  host_rdata = 32'(start_addr);
            IDX_END:    host_rdata = 32'(end_addr);
            IDX_PAGE:   host_rdata = {24'b0, limit, 4'b0};
            IDX_PTR:    host_rdata = 32'(ptr);
            IDX_CFG:    host_rdata = {22'b0, thr_code, 5'b0, burst_code};
            IDX_STATUS: host_rdata = {31'b0, irq_pend};
            default:    host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_burst.sv
// Burst sequencer: requests a burst when the FIFO count meets the
// threshold, waits for grant, then accepts the coded number of beats.
// Assumes beats arrive only after grant; extra beats are dropped.
module dma_burst #(
    parameter int FIFO_CW = 8,
    parameter int LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [FIFO_CW-1:0] fifo_count,
    input  logic [1:0]         thr_code,
    input  logic [2:0]         burst_code,
    input  logic               mem_gnt,
    input  logic               mem_beat,
    output logic               mem_req,
    output logic [LEN_W-1:0]   mem_len,
    output logic               beat_acc,
    output logic               busy
);
    import dma_pkg::*;

    localparam int CMP_W = (FIFO_CW > 5) ? FIFO_CW : 5;

    burst_st_t        state;
    logic [LEN_W-1:0] left;
    logic             thr_met;

    // Decode length, threshold and beat acceptance
    always_comb begin
        mem_len  = LEN_W'(len_of(burst_code));
        thr_met  = CMP_W'(fifo_count) >= CMP_W'(thr_of(thr_code));
        mem_req  = (state == ST_REQ) && en;
        busy     = (state == ST_DATA);
        beat_acc = busy && en && mem_beat;
    end

    // Burst state machine and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            left  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (en && thr_met) state <= ST_REQ;
                ST_REQ: begin
                    if (!en) begin
                        state <= ST_IDLE;
                    end else if (mem_gnt) begin
                        state <= ST_DATA;
                        left  <= mem_len;
                    end
                end
                ST_DATA: begin
                    if (!en) begin
                        state <= ST_IDLE;
                    end else if (mem_beat) begin
                        left <= left - 1'b1;
                        if (left == LEN_W'(1)) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_addr.sv
// Address pointer with wrap at the end address and power-of-two
// boundary interrupt. A host start-address write reloads the pointer.
// Assumes dword beats (step of 4 bytes) and end address dword aligned.
module dma_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [3:0]        limit,
    input  logic              load_ptr,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              beat_acc,
    input  logic              irq_clr,
    output logic [ADDR_W-1:0] ptr,
    output logic              irq
);
    localparam int SHIFT_W = 6;

    logic [ADDR_W-1:0] inc, nxt, mask;
    logic              hit;

    // Next address, boundary mask and boundary hit
    always_comb begin
        inc  = ptr + ADDR_W'(4);
        nxt  = (inc == end_addr) ? start_addr : inc;
        mask = (ADDR_W'(1) << (SHIFT_W'(5) + SHIFT_W'(limit))) - ADDR_W'(1);
        hit  = (limit != 4'd0) && ((nxt & mask) == '0);
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (load_ptr) ptr <= load_val;
        else if (beat_acc) ptr <= nxt;
    end

    // Pending interrupt: a new hit wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (beat_acc && hit)  irq <= 1'b1;
        else if (irq_clr)          irq <= 1'b0;
    end

endmodule

// File: rtl/audio_dma_chan.sv
// Top of one audio DMA channel: register file, burst sequencer and
// address generator. Linear addressing only; no translation.
module audio_dma_chan #(
    parameter int ADDR_W  = 32,
    parameter int FIFO_CW = 8,
    parameter int LEN_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [2:0]         host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic               irq,
    input  logic [FIFO_CW-1:0] fifo_count,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic [LEN_W-1:0]   mem_len,
    input  logic               mem_beat,
    output logic [ADDR_W-1:0]  mem_addr
);
    logic              en, load_ptr, irq_clr, beat_acc, busy;
    logic [ADDR_W-1:0] start_addr, end_addr, load_val, ptr;
    logic [3:0]        limit;
    logic [2:0]        burst_code;
    logic [1:0]        thr_code;

    dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ptr(ptr),
        .irq_pend(irq), .en(en), .start_addr(start_addr), .end_addr(end_addr),
        .limit(limit), .burst_code(burst_code), .thr_code(thr_code),
        .load_ptr(load_ptr), .load_val(load_val), .irq_clr(irq_clr)
    );

    dma_burst #(.FIFO_CW(FIFO_CW), .LEN_W(LEN_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .en(en), .fifo_count(fifo_count),
        .thr_code(thr_code), .burst_code(burst_code), .mem_gnt(mem_gnt),
        .mem_beat(mem_beat), .mem_req(mem_req), .mem_len(mem_len),
        .beat_acc(beat_acc), .busy(busy)
    );

    dma_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .end_addr(end_addr),
        .limit(limit), .load_ptr(load_ptr), .load_val(load_val),
        .beat_acc(beat_acc), .irq_clr(irq_clr), .ptr(ptr), .irq(irq)
    );

    // Beat address is the live pointer
    always_comb mem_addr = ptr;

endmodule

// File: rtl/audio_dma_chan_chk.sv
// Temporal checks for audio_dma_chan, attached by bind.
module audio_dma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              load_ptr,
    input logic              irq_clr,
    input logic              beat_acc,
    input logic              busy,
    input logic              mem_beat,
    input logic              mem_req,
    input logic              irq,
    input logic [ADDR_W-1:0] ptr,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] end_addr
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !irq && ptr == '0));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && !load_ptr && (ptr + ADDR_W'(4) != end_addr))
        |=> ptr == $past(ptr) + ADDR_W'(4));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_acc && !load_ptr && (ptr + ADDR_W'(4) == end_addr))
        |=> ptr == $past(start_addr));

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(beat_acc));

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_req_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> en);

    assert_stray_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_beat && !busy && !load_ptr) |=> $stable(ptr));

    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load_ptr) |=> $stable(ptr));

endmodule

bind audio_dma_chan audio_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .load_ptr(load_ptr),
    .irq_clr(irq_clr), .beat_acc(beat_acc), .busy(busy),
    .mem_beat(mem_beat), .mem_req(mem_req), .irq(irq), .ptr(ptr),
    .start_addr(start_addr), .end_addr(end_addr)
);

// File: tb/tb_audio_dma_chan.sv
// Scoreboard bench: driver tasks queue expectations, a monitor at the
// falling edge pops and compares them against the outputs.
module tb_audio_dma_chan;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;
    logic [7:0]  fifo_count = '0;
    logic        mem_req;
    logic        mem_gnt = 1'b0;
    logic [7:0]  mem_len;
    logic        mem_beat = 1'b0;
    logic [31:0] mem_addr;

    always #(CLK_P/2) clk = ~clk;

    audio_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .fifo_count(fifo_count), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_len(mem_len), .mem_beat(mem_beat), .mem_addr(mem_addr)
    );

    typedef struct {
        int          kind;   // 0..7 register index, 8 irq, 9 req, 10 len, 11 addr
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    pend  = 1'b0;
    bit    done  = 1'b0;

    // Monitor: compare queued expectations against outputs
    always @(negedge clk) begin
        if (pend) begin
            while (q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    8:       act = {31'b0, irq};
                    9:       act = {31'b0, mem_req};
                    10:      act = {24'b0, mem_len};
                    11:      act = mem_addr;
                    default: act = host_rdata;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
            pend = 1'b0;
        end
    end

    task automatic chk(input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        if (kind < 8) host_addr = kind[2:0];
        q.push_back(it);
        pend = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    // One full burst of n beats; optional status clear on the last beat
    task automatic burst(input int n, input bit clr_last);
        fifo_count = 8'd16;
        while (!mem_req) tick(1);
        mem_gnt = 1'b1; fifo_count = 8'd0;
        tick(1);
        mem_gnt = 1'b0;
        for (int i = 0; i < n; i++) begin
            mem_beat = 1'b1;
            if (clr_last && i == n - 1) begin
                host_wr = 1'b1; host_addr = 3'd6; host_wdata = 32'd1;
            end
            tick(1);
            mem_beat = 1'b0; host_wr = 1'b0;
        end
    endtask

    initial begin
        tick(5);
        chk(4, 32'h0, "R1 pointer");
        chk(0, 32'h0, "R1 enable");
        chk(6, 32'h0, "R1 status");
        chk(8, 32'h0, "R1 irq");
        chk(9, 32'h0, "R1 mem_req");
        chk(10, 32'h1, "R1 mem_len");
        rst_n = 1'b1;
        tick(1);

        wr(3'd1, 32'h0000_1000);
        wr(3'd2, 32'h0000_1080);
        chk(4, 32'h0000_1000, "R3 start write loads pointer");
        wr(3'd3, 32'hFFFF_0810);
        chk(3, 32'h0000_0010, "R10 page readback bit11 zero");
        wr(3'd5, 32'h0000_0102);
        chk(10, 32'h4, "R8 burst length code 2");

        wr(3'd0, 32'h0000_0001);
        chk(0, 32'h0, "R2 unmasked write ignored");
        wr(3'd0, 32'h0001_0001);
        chk(0, 32'h1, "R2 masked write sets enable");

        fifo_count = 8'd3; tick(3);
        chk(9, 32'h0, "R7 below threshold");
        fifo_count = 8'd4; tick(1);
        chk(9, 32'h1, "R7 threshold met");
        mem_gnt = 1'b1; fifo_count = 8'd0; tick(1); mem_gnt = 1'b0;
        for (int i = 0; i < 4; i++) begin mem_beat = 1'b1; tick(1); end
        mem_beat = 1'b0;
        chk(4, 32'h0000_1010, "R8 four beats accepted");
        chk(11, 32'h0000_1010, "R3 mem_addr follows pointer");
        chk(9, 32'h0, "R8 burst done no request");
        mem_beat = 1'b1; tick(2); mem_beat = 1'b0;
        chk(4, 32'h0000_1010, "R8 stray beat ignored");

        burst(4, 1'b0); burst(4, 1'b0);
        chk(8, 32'h0, "R5 no boundary yet");
        burst(4, 1'b0);
        chk(4, 32'h0000_1040, "R3 pointer at boundary");
        chk(8, 32'h1, "R5 64-byte boundary irq");
        chk(6, 32'h1, "R6 status pending");
        wr(3'd6, 32'h0);
        chk(8, 32'h1, "R6 zero write keeps irq");
        wr(3'd6, 32'h1);
        chk(8, 32'h0, "R6 one write clears irq");
        chk(6, 32'h0, "R6 status reads zero");

        burst(4, 1'b0); burst(4, 1'b0); burst(4, 1'b0); burst(4, 1'b0);
        chk(4, 32'h0000_1000, "R4 wrap to start");
        chk(8, 32'h1, "R5 boundary on wrap");

        burst(4, 1'b0); burst(4, 1'b0); burst(4, 1'b0);
        burst(4, 1'b1);
        chk(8, 32'h1, "R6 hit wins over clear");
        wr(3'd6, 32'h1);
        chk(8, 32'h0, "R6 clear after collision");

        wr(3'd3, 32'h0);
        burst(4, 1'b0); burst(4, 1'b0); burst(4, 1'b0); burst(4, 1'b0);
        chk(4, 32'h0000_1000, "R4 wrap with code 0");
        chk(8, 32'h0, "R5 code 0 no irq");

        fifo_count = 8'd16;
        while (!mem_req) tick(1);
        mem_gnt = 1'b1; fifo_count = 8'd0; tick(1); mem_gnt = 1'b0;
        mem_beat = 1'b1; tick(2); mem_beat = 1'b0;
        wr(3'd0, 32'h0001_0000);
        tick(2);
        mem_beat = 1'b1; tick(3); mem_beat = 1'b0;
        chk(4, 32'h0000_1008, "R9 pointer held after disable");
        fifo_count = 8'd16; tick(3);
        chk(9, 32'h0, "R9 no request while disabled");
        fifo_count = 8'd0;
        wr(3'd0, 32'h0001_0001);
        burst(4, 1'b0);
        chk(4, 32'h0000_1018, "R9 resume from held pointer");

        wr(3'd5, 32'h0000_0300);
        chk(10, 32'h1, "R8 burst length code 0");
        fifo_count = 8'd15; tick(2);
        chk(9, 32'h0, "R7 15 below threshold 16");
        fifo_count = 8'd16; tick(1);
        chk(9, 32'h1, "R7 16 meets threshold");
        mem_gnt = 1'b1; fifo_count = 8'd0; tick(1); mem_gnt = 1'b0;
        mem_beat = 1'b1; tick(1); mem_beat = 1'b0;
        chk(4, 32'h0000_101C, "R8 single beat burst");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule